// File: doc/BRIEF.md
# Isolated-zero gap filler

This block is a small clocked filter for a serial bit stream. One bit enters on every clock edge and passes through a three-stage state register. The output is the last stage, so each input bit comes out two clock periods after the edge that captured it. A single 0 with a 1 on each side is replaced by a 1. Runs of two or more 0s, runs of 1s and isolated 1s leave the block as they entered it, only delayed.

The block is meant for cleaning up a one-bit status or detect line, where a glitch one sample wide must not break an asserted run. A build parameter chooses one of two structures. The first is a set of sum-of-products next-state equations. The second is a plain shift register whose stages are all forced to 1 when a new 1 arrives while the middle stage already holds a 1. Both structures give the same sequence at the output. Reset is synchronous and active high.

Top module: `gapfill_filter`

## Requirements
- R1: While `rst` is sampled high at a rising edge, every state stage is 0 after that edge and `dout` reads 0, whatever `din` is.
- R2: With reset low, `dout` after edge k equals `din` as it was sampled at edge k-2, except where R3 fills a gap. A stream with no lone 0 comes out unchanged and two edges late.
- R3: A single 0 sampled with a 1 on each side (the pattern 1,0,1 on consecutive edges) comes out as 1,1,1.
- R4: Two or more consecutive 0s between 1s pass to the output unchanged. An isolated 1 also passes unchanged.
- R5: Reset wins over the fill action. If `rst` is high at an edge where `din` is 1 and the middle stage holds 1, the state still becomes all zero, and with `din` held at 0 afterwards `dout` stays 0.
- R6: For every stream, `dout` after edge k equals d[k-2] OR (d[k-3] AND d[k-1]). Here d[j] is `din` sampled at edge j, and any sample taken at or before the last reset edge counts as 0.
- R7: The sum-of-products build (IMPL = IMPL_SOP) and the shift-with-set build (IMPL = IMPL_SHIFT_SET) produce the same `dout` sequence for the same `din` and `rst` sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Rising-edge clock |
| rst  | input  | 1 | Synchronous reset, active high |
| din  | input  | 1 | Serial input bit, sampled on every rising edge |
| dout | output | 1 | Filtered bit, taken directly from the last state stage |

## Verification
A wrong internal state shows up at `dout` within at most two edges. A bad first or middle stage reaches the output stage within two edges. An error in the fill term produces a wrong 1, or a missing 1, at the output in the edge after the gap has moved into the last stage. An error in reset priority shows as 1s on `dout` for up to three edges after a reset that was applied with `din` high and the middle stage holding 1. The bench therefore compares `dout` on every edge against the windowed formula of R6. It also runs both builds side by side, so a fault that only one structure has still shows up as a mismatch.

// File: rtl/gapfill_pkg.sv
package gapfill_pkg;

    localparam int STAGES = 3;

    typedef enum logic [0:0] {
        IMPL_SOP       = 1'b0,
        IMPL_SHIFT_SET = 1'b1
    } impl_e;

    // s1 is the newest sample, s3 drives the output
    typedef struct packed {
        logic s3;
        logic s2;
        logic s1;
    } gap_state_t;

    // Sum-of-products next-state equations
    function automatic gap_state_t f_next_sop(input gap_state_t cur, input logic bit_in);
        gap_state_t nxt;
        nxt.s1 = bit_in;
        nxt.s2 = cur.s1 | (cur.s2 & bit_in);
        nxt.s3 = cur.s2;
        return nxt;
    endfunction

    // Plain shift step, used with the set term
    function automatic gap_state_t f_shift(input gap_state_t cur, input logic bit_in);
        gap_state_t nxt;
        nxt.s1 = bit_in;
        nxt.s2 = cur.s1;
        nxt.s3 = cur.s2;
        return nxt;
    endfunction

    // Fill condition: a new 1 while the middle stage holds 1
    function automatic logic f_fill(input gap_state_t cur, input logic bit_in);
        return cur.s2 & bit_in;
    endfunction

endpackage

// File: rtl/gapfill_stage.sv
module gapfill_stage (
    input  logic clk,
    input  logic clr,
    input  logic set,
    input  logic d,
    output logic q
);

    // Priority: clear, then set, then data
    always_ff @(posedge clk) begin
        if (clr)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
        else
            q <= d;
    end

    p_clear_wins_r5: assert property (@(posedge clk) clr |=> !q)
        else $error("stage not cleared");

    p_set_loads_r3: assert property (@(posedge clk) disable iff (clr) set |=> q)
        else $error("stage not set");

endmodule

// File: rtl/gapfill_ns_sop.sv
module gapfill_ns_sop
    import gapfill_pkg::*;
(
    input  gap_state_t        cur,
    input  logic              bit_in,
    output logic [STAGES-1:0] d_vec,
    output logic [STAGES-1:0] set_vec
);

    always_comb begin
        d_vec   = f_next_sop(cur, bit_in);
        set_vec = '0;
    end

endmodule

// File: rtl/gapfill_ns_shift.sv
module gapfill_ns_shift
    import gapfill_pkg::*;
(
    input  gap_state_t        cur,
    input  logic              bit_in,
    output logic [STAGES-1:0] d_vec,
    output logic [STAGES-1:0] set_vec
);

    logic fill;

    always_comb begin
        fill    = f_fill(cur, bit_in);
        d_vec   = f_shift(cur, bit_in);
        set_vec = {STAGES{fill}};
    end

endmodule

// File: rtl/gapfill_filter.sv
module gapfill_filter
    import gapfill_pkg::*;
#(
    parameter impl_e IMPL = IMPL_SOP
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] st_q;
    logic [STAGES-1:0] d_vec;
    logic [STAGES-1:0] set_vec;
    gap_state_t        cur;

    assign cur = gap_state_t'(st_q);

    generate
        if (IMPL == IMPL_SOP) begin : g_sop
            gapfill_ns_sop u_ns (
                .cur     (cur),
                .bit_in  (din),
                .d_vec   (d_vec),
                .set_vec (set_vec)
            );
        end else begin : g_shift
            gapfill_ns_shift u_ns (
                .cur     (cur),
                .bit_in  (din),
                .d_vec   (d_vec),
                .set_vec (set_vec)
            );
        end
    endgenerate

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            gapfill_stage u_stage (
                .clk (clk),
                .clr (rst),
                .set (set_vec[g]),
                .d   (d_vec[g]),
                .q   (st_q[g])
            );
        end
    endgenerate

    assign dout = cur.s3;

    p_reset_clears_r1: assert property (@(posedge clk) rst |=> (st_q == '0))
        else $error("reset did not clear state");

    p_delay_chain_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cur.s1 == $past(din)) && (cur.s3 == $past(cur.s2)))
        else $error("delay chain broken");

    p_gap_fill_r3: assert property (@(posedge clk) disable iff (rst)
        (din && cur.s2) |=> (st_q == '1))
        else $error("gap not filled");

    p_no_phantom_r4: assert property (@(posedge clk) disable iff (rst)
        (!cur.s1 && !din) |=> !cur.s2)
        else $error("middle stage set without source");

    p_unreachable_r6: assert property (@(posedge clk) disable iff (rst)
        !(cur.s3 && !cur.s2 && cur.s1))
        else $error("unreachable state entered");

endmodule

// File: tb/gapfill_filter_tb_top.sv
`timescale 1ns/100ps
module gapfill_filter_tb_top;
    import gapfill_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic dout;
    logic dout_alt;

    int checks = 0;
    int errors = 0;
    logic [3:0] hist = '0;  // hist[0] newest sample
    bit done = 0;

    always #2.5 clk = ~clk;

    gapfill_filter #(.IMPL(IMPL_SOP)) dut_i (
        .clk (clk), .rst (rst), .din (din), .dout (dout)
    );

    gapfill_filter #(.IMPL(IMPL_SHIFT_SET)) dut_shift_i (
        .clk (clk), .rst (rst), .din (din), .dout (dout_alt)
    );

    localparam int NV = 6;
    localparam logic [15:0] PAT [NV] = '{
        16'b1010_1010_1010_1010,
        16'b1001_1000_1100_0111,
        16'b1111_0000_1111_0000,
        16'b1011_0110_1101_0010,
        16'b0100_0100_0010_0000,
        16'b1100_0011_1010_0101
    };

    function automatic string tag_of(input int i);
        case (i)
            0:       return "R3";
            1:       return "R4";
            2:       return "R2";
            4:       return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: dout=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic r, input logic b, input string tag);
        logic exp;
        @(negedge clk);
        rst = r;
        din = b;
        @(posedge clk);
        #1;
        if (r) hist = '0;
        else   hist = {hist[2:0], b};
        exp = hist[2] | (hist[1] & hist[3]);
        check(tag, dout, exp);
        check("R7", dout_alt, dout);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with din low and then high
        step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, "R1");
        step(1'b1, 1'b1, "R1");

        for (int i = 0; i < NV; i++) begin
            for (int j = 15; j >= 0; j--) step(1'b0, PAT[i][j], tag_of(i));
        end
        for (int j = 0; j < 4; j++) step(1'b0, 1'b0, "R2");

        // R3: single gap directly after reset
        step(1'b1, 1'b0, "R1");
        step(1'b0, 1'b1, "R3");
        step(1'b0, 1'b0, "R3");
        step(1'b0, 1'b1, "R3");
        step(1'b0, 1'b0, "R3");
        step(1'b0, 1'b0, "R4");
        step(1'b0, 1'b1, "R4");
        for (int j = 0; j < 4; j++) step(1'b0, 1'b0, "R4");

        // R5: reset together with the fill condition
        step(1'b0, 1'b1, "R5");
        step(1'b0, 1'b1, "R5");
        step(1'b1, 1'b1, "R5");
        for (int j = 0; j < 4; j++) step(1'b0, 1'b0, "R5");

        // R1: reset in the middle of a run of ones
        step(1'b0, 1'b1, "R1");
        step(1'b0, 1'b1, "R1");
        step(1'b0, 1'b1, "R1");
        step(1'b1, 1'b1, "R1");
        step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, "R1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule